// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog with a single control word on a simple register port. Software enables it, picks one of eight prescaler tick lines that advance an internal counter, and chooses what happens when that counter wraps: either a one-cycle system-reset request or a one-cycle interrupt pulse. An external pending latch is expected to capture the interrupt pulse. A reset generator outside the block is expected to act on the reset request. Software keeps the watchdog quiet by writing a restart command before the counter wraps. A force command fires the configured action at once.

Once the configuration is set, software can freeze it with a lock bit that only a system reset releases. While the configuration is frozen, the restart and force commands still work. By default the counter stops while the CPU sits in debug mode, and a configuration bit lets it keep running. A status bit reports when the counter has reached the upper half of its range. A read-only flag holds whether the last system reset came from the watchdog or from the external pin. The reset generator supplies that origin on an input while reset is held.

Top module: `wdt_lockable`

## Requirements
- R1: While the synchronous active-low reset is held, the control word reads zero except the reset-cause bit, and both action outputs stay low.
- R2: Control word layout: bit 0 enable, bits 3:1 prescaler select, bit 4 action mode (1 = reset request, 0 = interrupt), bit 8 lock, bit 9 debug-run. These bits are written by a write. Bits 6 and 7 read as zero. All bits above 10 read as zero.
- R3: While enabled, the counter advances by one on each clock where tick line `tick_i[prescaler]` is high. Other tick lines have no effect. While disabled, the counter is held at zero.
- R4: A selected tick that arrives while the counter holds its maximum (2^CNT_W − 1) wraps the counter to zero. In the next cycle it gives a one-cycle pulse on `irq_o` when mode is 0, or on `rst_req_o` when mode is 1. Neither output pulses while the watchdog is disabled.
- R5: A write with bit 6 set clears the counter. It takes priority over a tick in the same cycle, so no wrap occurs.
- R6: A write with bit 7 set fires the configured action in the next cycle when the watchdog is already enabled, and has no effect when it is disabled.
- R7: After the lock bit is set, writes leave the enable, prescaler, mode, lock and debug-run bits unchanged, but restart and force still act. Only a system reset clears the lock.
- R8: While `dbg_i` is high and debug-run is 0, ticks are ignored. With debug-run set, counting continues. When the block is built without debug support (DBG_SUP = 0), bit 9 reads as zero.
- R9: Bit 10 reads 1 exactly when the counter is at least 2^(CNT_W−1).
- R10: Bit 5 holds the value of `rst_by_wdt_i` sampled during the last reset (1 = last reset came from the watchdog). It does not change outside reset, and writes do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous system reset, active low |
| wr_i | input | 1 | Write strobe for the control word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Control and status word read view |
| tick_i | input | 8 | Prescaler tick lines, one per prescaler setting |
| dbg_i | input | 1 | CPU is in debug mode |
| rst_by_wdt_i | input | 1 | Origin of the current reset, sampled while reset is held |
| irq_o | output | 1 | One-cycle interrupt pulse |
| rst_req_o | output | 1 | One-cycle system-reset request pulse |

## Verification
The hardest state to reach from the ports is the cycle where a restart write meets a selected tick while the counter sits at its maximum. The counter is invisible except through the half flag and the wrap pulse. The bench therefore counts the exact number of selected ticks to place the counter at the maximum, and only then issues the restart together with a tick. Lock behaviour is reached the same way. The bench locks a known configuration, attempts overwrites, and then issues restart and force. Long random runs with a narrow counter and periodic resets carrying a random origin mix the lock, debug and prescaler conditions.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Prescaler field width is fixed by the control word layout (bits 3:1)
  localparam int PSC_W    = 3;
  localparam int N_TICK   = 1 << PSC_W;

  localparam int B_EN     = 0;
  localparam int B_PSC    = 1;
  localparam int B_MODE   = 4;
  localparam int B_CAUSE  = 5;
  localparam int B_KICK   = 6;
  localparam int B_FORCE  = 7;
  localparam int B_LOCK   = 8;
  localparam int B_DBGRUN = 9;
  localparam int B_HALF   = 10;

  typedef struct packed {
    logic             dbgrun;
    logic             lock;
    logic             mode;
    logic [PSC_W-1:0] psc;
    logic             en;
  } wdt_cfg_t;

  function automatic wdt_cfg_t cfg_from_word(logic [31:0] w, logic dbg_ok);
    wdt_cfg_t c;
    c.en     = w[B_EN];
    c.psc    = w[B_PSC +: PSC_W];
    c.mode   = w[B_MODE];
    c.lock   = w[B_LOCK];
    c.dbgrun = w[B_DBGRUN] & dbg_ok;
    return c;
  endfunction

  function automatic logic [31:0] status_word(wdt_cfg_t c, logic cause, logic half);
    logic [31:0] w;
    w = '0;
    w[B_EN]           = c.en;
    w[B_PSC +: PSC_W] = c.psc;
    w[B_MODE]         = c.mode;
    w[B_CAUSE]        = cause;
    w[B_LOCK]         = c.lock;
    w[B_DBGRUN]       = c.dbgrun;
    w[B_HALF]         = half;
    return w;
  endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter bit DBG_SUP = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        rst_by_wdt_i,
  output wdt_cfg_t    cfg_o,
  output logic        cause_o,
  output logic        kick_o,
  output logic        force_o
);

  wdt_cfg_t cfg_q;
  logic     cause_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      cause_q <= rst_by_wdt_i;
    end else if (wr_i && !cfg_q.lock) begin
      cfg_q   <= cfg_from_word(wdata_i, DBG_SUP);
    end
  end

  assign cfg_o   = cfg_q;
  assign cause_o = cause_q;
  assign kick_o  = wr_i & wdata_i[B_KICK];
  assign force_o = wr_i & wdata_i[B_FORCE];

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic             kick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             half_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic at_upper_half(logic [CNT_W-1:0] v);
    return v[CNT_W-1];
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i || kick_i) cnt_q <= '0;
    else if (step_i)                cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i & step_i & ~kick_i & (cnt_q == CNT_MAX);
  assign half_o = at_upper_half(cnt_q);

endmodule

// File: rtl/wdt_action.sv
module wdt_action (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_i,
  input  logic wrap_i,
  input  logic force_i,
  output logic irq_o,
  output logic rst_req_o
);

  logic fire;
  assign fire = en_i & (wrap_i | force_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o     <= fire & ~mode_i;
      rst_req_o <= fire & mode_i;
    end
  end

endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter bit DBG_SUP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_TICK-1:0] tick_i,
  input  logic              dbg_i,
  input  logic              rst_by_wdt_i,
  output logic              irq_o,
  output logic              rst_req_o
);

  wdt_cfg_t         cfg;
  logic             cause;
  logic             kick;
  logic             force_cmd;
  logic             run_ok;
  logic             step;
  logic             wrap;
  logic             half;
  logic [CNT_W-1:0] cnt_q;

  wdt_ctrl_reg #(.DBG_SUP(DBG_SUP)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .wdata_i      (wdata_i),
    .rst_by_wdt_i (rst_by_wdt_i),
    .cfg_o        (cfg),
    .cause_o      (cause),
    .kick_o       (kick),
    .force_o      (force_cmd)
  );

  assign run_ok = ~dbg_i | cfg.dbgrun;
  assign step   = tick_i[cfg.psc] & run_ok;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg.en),
    .step_i (step),
    .kick_i (kick),
    .cnt_o  (cnt_q),
    .wrap_o (wrap),
    .half_o (half)
  );

  wdt_action u_act (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cfg.en),
    .mode_i    (cfg.mode),
    .wrap_i    (wrap),
    .force_i   (force_cmd),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  assign rdata_o = status_word(cfg, cause, half);

endmodule

// File: rtl/wdt_lockable_chk.sv
module wdt_lockable_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [31:0]      wdata_i,
  input logic             dbg_i,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             cfg_en,
  input logic             cfg_mode,
  input logic             cfg_lock,
  input logic             cfg_dbgrun,
  input logic [7:0]       cfg_bits,
  input logic             cause,
  input logic [CNT_W-1:0] cnt
);

  // R7
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_lock |=> cfg_lock);

  // R7
  lock_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_lock |=> $stable(cfg_bits));

  // R3
  off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en |=> (cnt == '0));

  // R5
  kick_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[6]) |=> (cnt == '0));

  // R8
  dbg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en && dbg_i && !cfg_dbgrun && !(wr_i && wdata_i[6])) |=> $stable(cnt));

  // R4
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(cfg_en && !cfg_mode));

  // R4
  rst_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(cfg_en && cfg_mode));

  // R10
  cause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(cause));

endmodule

bind wdt_lockable wdt_lockable_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .dbg_i      (dbg_i),
  .irq_o      (irq_o),
  .rst_req_o  (rst_req_o),
  .cfg_en     (cfg.en),
  .cfg_mode   (cfg.mode),
  .cfg_lock   (cfg.lock),
  .cfg_dbgrun (cfg.dbgrun),
  .cfg_bits   (cfg),
  .cause      (cause),
  .cnt        (cnt_q)
);

// File: tb/wdt_lockable_bench.sv
module wdt_lockable_bench;

  localparam int CW    = 6;
  localparam int MAXC  = (1 << CW) - 1;
  localparam int HALFC = 1 << (CW - 1);

  logic        clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  tick = '0;
  logic        dbg = 1'b0;
  logic        cause_in = 1'b0;
  logic [31:0] rdata, rdata2;
  logic        irq, rstq, irq2, rstq2;

  wdt_lockable #(.CNT_W(CW), .DBG_SUP(1'b1)) u_wdt_lockable (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .tick_i(tick), .dbg_i(dbg), .rst_by_wdt_i(cause_in), .irq_o(irq), .rst_req_o(rstq)
  );

  wdt_lockable #(.CNT_W(CW), .DBG_SUP(1'b0)) u_wdt_lockable_nodbg (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata2),
    .tick_i(tick), .dbg_i(dbg), .rst_by_wdt_i(cause_in), .irq_o(irq2), .rst_req_o(rstq2)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  // independent reference state
  logic       m_en, m_mode, m_lock, m_dbr, m_cause;
  logic [2:0] m_psc;
  int         m_cnt;

  function automatic logic [31:0] cfg_word();
    return {22'd0, m_dbr, m_lock, 3'd0, m_mode, m_psc, m_en};
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = cfg_word();
    w[5]  = m_cause;
    w[10] = (m_cnt >= HALFC);
    return w;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input string tag, input logic w, input logic [31:0] d,
                       input logic [7:0] t, input logic g);
    logic tk, kick, frc, ovf, fire, e_irq, e_rst;
    wr = w; wdata = d; tick = t; dbg = g;
    tk    = m_en && t[m_psc] && (!g || m_dbr);
    kick  = w && d[6];
    frc   = w && d[7] && m_en;
    ovf   = tk && !kick && (m_cnt == MAXC);
    fire  = ovf || frc;
    e_irq = fire && !m_mode;
    e_rst = fire && m_mode;
    if (!m_en || kick) m_cnt = 0;
    else if (tk)       m_cnt = (m_cnt + 1) & MAXC;
    if (w && !m_lock) begin
      m_en = d[0]; m_psc = d[3:1]; m_mode = d[4]; m_lock = d[8]; m_dbr = d[9];
    end
    @(posedge clk); #1;
    chk(tag, "irq", {31'd0, irq}, {31'd0, e_irq});
    chk(tag, "rst_req", {31'd0, rstq}, {31'd0, e_rst});
    chk(tag, "ctrl", rdata, exp_word());
    wr = 1'b0;
  endtask

  task automatic do_reset(input string tag, input logic c);
    rst_n = 1'b0; cause_in = c; wr = 1'b0; tick = '0; dbg = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    m_en = 0; m_mode = 0; m_lock = 0; m_dbr = 0; m_psc = 0; m_cnt = 0; m_cause = c;
    chk(tag, "reset ctrl", rdata, exp_word());
    chk(tag, "reset outs", {30'd0, irq, rstq}, 32'd0);
    rst_n = 1'b1;
    cause_in = ~c;
  endtask

  task automatic ticks(input string tag, input int n, input logic [7:0] t, input logic g);
    for (int i = 0; i < n; i++) cycle(tag, 1'b0, 32'd0, t, g);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog timeout actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    do_reset("R1", 1'b0);
    // R2: write all config bits, commands set while disabled; R6 force ignored when off
    cycle("R2", 1'b1, 32'hFFFF_FEFF, 8'h00, 1'b0);
    chk("R2", "ctrl layout", rdata, 32'h0000_021F);
    do_reset("R1", 1'b0);
    // R3: enable, prescaler 1; other tick lines do nothing
    cycle("R3", 1'b1, 32'h0000_0003, 8'h00, 1'b0);
    ticks("R3", 20, 8'hFD, 1'b0);
    ticks("R9", 40, 8'h02, 1'b0);
    // R4: interrupt wrap
    ticks("R4", 30, 8'h02, 1'b0);
    // R4: reset-request wrap
    cycle("R4", 1'b1, 32'h0000_0013, 8'h00, 1'b0);
    ticks("R4", 70, 8'h02, 1'b0);
    // R5: restart meeting a tick at the maximum
    cycle("R5", 1'b1, 32'h0000_0043, 8'h00, 1'b0);
    ticks("R5", MAXC, 8'h02, 1'b0);
    cycle("R5", 1'b1, cfg_word() | 32'h40, 8'h02, 1'b0);
    ticks("R5", 5, 8'h02, 1'b0);
    // R6: force while enabled, both modes
    cycle("R6", 1'b1, cfg_word() | 32'h80, 8'h00, 1'b0);
    cycle("R6", 1'b1, 32'h0000_0003, 8'h00, 1'b0);
    cycle("R6", 1'b1, cfg_word() | 32'h80, 8'h00, 1'b0);
    // R8: debug pause and debug-run
    cycle("R8", 1'b1, 32'h0000_0043, 8'h00, 1'b0);
    ticks("R8", 40, 8'h02, 1'b1);
    cycle("R8", 1'b1, 32'h0000_0203, 8'h00, 1'b1);
    chk("R8", "no debug support bit9", {31'd0, rdata2[9]}, 32'd0);
    ticks("R8", 40, 8'h02, 1'b1);
    // R7: lock, overwrite attempts, commands still work
    cycle("R7", 1'b1, 32'h0000_0103, 8'h00, 1'b0);
    cycle("R7", 1'b1, 32'h0000_0000, 8'h02, 1'b0);
    cycle("R7", 1'b1, 32'h0000_0210, 8'h02, 1'b0);
    ticks("R7", 40, 8'h02, 1'b0);
    cycle("R7", 1'b1, 32'h0000_0040, 8'h02, 1'b0);
    cycle("R7", 1'b1, 32'h0000_0080, 8'h00, 1'b0);
    // R10: reset origin capture, lock released by reset
    do_reset("R10", 1'b1);
    cycle("R10", 1'b1, 32'h0000_0020, 8'h00, 1'b0);
    do_reset("R10", 1'b0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic        w;
      logic [31:0] d;
      if (i % 600 == 599) do_reset("R10", 1'($urandom));
      w = ($urandom % 12 == 0);
      d = $urandom;
      d[8] = ($urandom % 10 == 0);
      d[7] = ($urandom % 6 == 0);
      d[6] = ($urandom % 3 == 0);
      d[0] = ($urandom % 5 != 0);
      cycle("R3", w, d, 8'($urandom), ($urandom % 6 == 0));
    end
    finish_run();
  end

endmodule